// File: doc/BRIEF.md
# Performance Monitor Unit with Packed Control Word

This block counts activity inside a processor core. It has one cycle counter and two event counters, each 32 bits wide. The core drives a vector of single-cycle event pulses, one bit per event kind. Each event counter carries an 8-bit selector that picks one bit of that vector. The cycle counter advances on every clock, or once every 64 clocks when the prescale option is set.

When a counter wraps from all-ones to zero, it sets a sticky overflow flag. Each flag can raise the interrupt request when its enable is set. Software clears a flag by writing a one to it. A small register bus with four word addresses gives access to the control word and to all three counters.

Every control function sits in one 32-bit word: global enable, the two counter resets, prescale, the three interrupt enables, the three overflow flags and both event selectors. Holes in this word ignore writes and always read as zero. A driver can read the word, change a few fields and write it back in one access. Writing back the value it read also clears any flags that were set.

Top module: `perfmon_unit`

## Requirements
- R1: After synchronous reset the control word reads 0x0FFFF000: both selectors are 0xFF and all other fields are 0. All three counters read 0 and `irq` is 0.
- R2: Bus address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write takes effect at the clock edge where `reg_we` is high. `reg_rdata` shows the addressed register one cycle after the address is presented, and a counter can be loaded directly by a write.
- R3: Counting happens only while control bit 0 (enable) is 1. With bit 3 clear, the cycle counter advances by exactly 1 on every enabled clock edge.
- R4: With control bit 3 set, the cycle counter advances once per 64 enabled clock edges, on the 64th, 128th and so on. The prescale divider is cleared together with the cycle counter.
- R5: Writing 1 to control bit 1 clears both event counters at that edge. Writing 1 to bit 2 clears the cycle counter and its prescale divider. Both bits always read back as 0.
- R6: Bits 19:12 select the event for counter 0 and bits 27:20 select the event for counter 1. A code c below 23 adds `evt_pulse[c]` on each enabled edge. Codes 23 and above, including 0xFF, count nothing.
- R7: A wrap from 0xFFFFFFFF to 0 sets an overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter. A flag that is already set stays set through a later wrap.
- R8: Writing 1 to a flag bit clears that flag and writing 0 leaves it unchanged. If a wrap happens in the same cycle as the clearing write, the flag stays set.
- R9: `irq` is the OR, over the counters, of each overflow flag ANDed with its interrupt enable: bit 4 for event counter 0, bit 5 for event counter 1, bit 6 for the cycle counter. `irq` changes at the same edge as the flags and enables.
- R10: Write data to the control word is masked with 0x0FFFF77F. Bits 7, 11 and 31:28 always read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| evt_pulse | input | EVT_W | Single-cycle event pulses from the core |
| irq | output | 1 | Registered interrupt request |

## Verification
A counter update, a flag change and the new `irq` value all appear at the same clock edge that samples the enable, the event pulse or the write. Read data arrives one edge after the address is presented. Inputs change on the falling edge. Each read samples `reg_rdata` on the next falling edge, so every read returns the state left by all preceding rising edges. Expected counts come from counting, in the bench, the rising edges that pass while the enable is set: the edge of the enabling write adds nothing, and the edge of the disabling write still counts.

// File: rtl/perfmon_pkg.sv
`timescale 1ns/1ps
package perfmon_pkg;
  localparam int CTRL_W   = 32;
  localparam int SEL_W    = 8;
  localparam int NUM_EVT  = 2;
  localparam int NUM_CNT  = NUM_EVT + 1;   // index NUM_EVT is the cycle counter
  localparam int ADDR_W   = 2;

  // control word field positions
  localparam int B_EN      = 0;
  localparam int B_CLR_EV  = 1;
  localparam int B_CLR_CYC = 2;
  localparam int B_PRESC   = 3;
  localparam int B_IE_LO   = 4;
  localparam int B_OVF_LO  = 8;
  localparam int B_SEL0_LO = 12;
  localparam int B_SEL1_LO = 20;

  localparam logic [CTRL_W-1:0] WR_MASK  = 32'h0FFF_F77F;
  localparam logic [SEL_W-1:0]  SEL_NONE = 8'hFF;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CYC  = 2'd1;
  localparam logic [ADDR_W-1:0] A_EV0  = 2'd2;
  localparam logic [ADDR_W-1:0] A_EV1  = 2'd3;
endpackage

// File: rtl/perfmon_evt_sel.sv
`timescale 1ns/1ps
module perfmon_evt_sel #(
  parameter int EVT_W = 23,
  parameter int SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [EVT_W-1:0] pulses,
  output logic             hit
);
  // codes outside the pulse vector match no bit and count nothing
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < EVT_W; k++) begin
      if (sel == SEL_W'(k)) hit = pulses[k];
    end
  end
endmodule

// File: rtl/perfmon_presc.sv
`timescale 1ns/1ps
module perfmon_presc #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic slow,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr)        div_q <= '0;
    else if (run && slow)  div_q <= div_q + 1'b1;
  end

  assign tick = run && (!slow || (&div_q));
endmodule

// File: rtl/perfmon_counter.sv
`timescale 1ns/1ps
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // priority: clear, then direct load, then increment
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (ld)    cnt <= ld_val;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !clr && !ld && (&cnt);
endmodule

// File: rtl/perfmon_ctrl.sv
`timescale 1ns/1ps
module perfmon_ctrl
  import perfmon_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [CTRL_W-1:0]             wdata,
  input  logic [NUM_CNT-1:0]            wrap,
  output logic                          en_q,
  output logic                          presc_q,
  output logic [NUM_CNT-1:0]            ie_q,
  output logic [NUM_CNT-1:0]            flag_q,
  output logic [NUM_EVT-1:0][SEL_W-1:0] sel_q,
  output logic                          clr_ev,
  output logic                          clr_cyc,
  output logic                          irq_q,
  output logic [CTRL_W-1:0]             word
);
  logic [CTRL_W-1:0]  wm;
  logic [NUM_CNT-1:0] ie_nxt;
  logic [NUM_CNT-1:0] w1c;
  logic [NUM_CNT-1:0] flag_nxt;
  logic               unused_holes;

  assign wm           = wdata & WR_MASK;
  assign unused_holes = ^{wm[CTRL_W-1:B_SEL1_LO+SEL_W], wm[B_SEL0_LO-1], wm[B_OVF_LO-1]};

  assign clr_ev  = wr && wm[B_CLR_EV];
  assign clr_cyc = wr && wm[B_CLR_CYC];

  always_comb begin
    ie_nxt   = wr ? wm[B_IE_LO +: NUM_CNT] : ie_q;
    w1c      = wr ? wm[B_OVF_LO +: NUM_CNT] : '0;
    // a wrap in the clearing cycle wins over the clear
    flag_nxt = (flag_q & ~w1c) | wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      presc_q <= 1'b0;
      ie_q    <= '0;
      flag_q  <= '0;
      sel_q   <= {NUM_EVT{SEL_NONE}};
      irq_q   <= 1'b0;
    end else begin
      if (wr) begin
        en_q     <= wm[B_EN];
        presc_q  <= wm[B_PRESC];
        sel_q[0] <= wm[B_SEL0_LO +: SEL_W];
        sel_q[1] <= wm[B_SEL1_LO +: SEL_W];
      end
      ie_q   <= ie_nxt;
      flag_q <= flag_nxt;
      irq_q  <= |(flag_nxt & ie_nxt);
    end
  end

  always_comb begin
    word                       = '0;
    word[B_EN]                 = en_q;
    word[B_PRESC]              = presc_q;
    word[B_IE_LO +: NUM_CNT]   = ie_q;
    word[B_OVF_LO +: NUM_CNT]  = flag_q;
    word[B_SEL0_LO +: SEL_W]   = sel_q[0];
    word[B_SEL1_LO +: SEL_W]   = sel_q[1];
  end
endmodule

// File: rtl/perfmon_unit.sv
`timescale 1ns/1ps
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 23,
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq
);
  localparam int CYC_IDX = NUM_EVT;

  logic                          en_q, presc_q, clr_ev, clr_cyc, tick;
  logic [NUM_CNT-1:0]            ie_q, flag_q, wrap;
  logic [NUM_EVT-1:0][SEL_W-1:0] sel_q;
  logic [CTRL_W-1:0]             ctrl_word;
  logic [CNT_W-1:0]              cnt_q [NUM_CNT];
  logic [CNT_W-1:0]              cyc_cnt, ev0_cnt, ev1_cnt;

  perfmon_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_we && (reg_addr == A_CTRL)),
    .wdata   (reg_wdata),
    .wrap    (wrap),
    .en_q    (en_q),
    .presc_q (presc_q),
    .ie_q    (ie_q),
    .flag_q  (flag_q),
    .sel_q   (sel_q),
    .clr_ev  (clr_ev),
    .clr_cyc (clr_cyc),
    .irq_q   (irq),
    .word    (ctrl_word)
  );

  perfmon_presc #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_cyc),
    .run  (en_q),
    .slow (presc_q),
    .tick (tick)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_ADDR = (i < NUM_EVT) ? ADDR_W'(i + 2) : A_CYC;
    logic inc_i, clr_i;

    if (i < NUM_EVT) begin : g_evt
      logic hit;
      perfmon_evt_sel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
        .sel    (sel_q[i]),
        .pulses (evt_pulse),
        .hit    (hit)
      );
      assign inc_i = en_q && hit;
      assign clr_i = clr_ev;
    end else begin : g_cyc
      assign inc_i = tick;
      assign clr_i = clr_cyc;
    end

    perfmon_counter #(.W(CNT_W)) u_counter (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_i),
      .ld     (reg_we && (reg_addr == MY_ADDR)),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .inc    (inc_i),
      .cnt    (cnt_q[i]),
      .wrap   (wrap[i])
    );
  end

  assign ev0_cnt = cnt_q[0];
  assign ev1_cnt = cnt_q[1];
  assign cyc_cnt = cnt_q[CYC_IDX];

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_word;
        A_CYC:   reg_rdata <= CTRL_W'(cyc_cnt);
        A_EV0:   reg_rdata <= CTRL_W'(ev0_cnt);
        default: reg_rdata <= CTRL_W'(ev1_cnt);
      endcase
    end
  end
endmodule

// File: rtl/perfmon_unit_chk.sv
`timescale 1ns/1ps
module perfmon_unit_chk
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CTRL_W-1:0] reg_rdata,
  input logic              irq,
  input logic              en_q,
  input logic              presc_q,
  input logic [NUM_CNT-1:0] ie_q,
  input logic [NUM_CNT-1:0] flag_q,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [CNT_W-1:0]  ev0_cnt,
  input logic [CNT_W-1:0]  ev1_cnt
);
  localparam logic [CTRL_W-1:0] RD_MASK = 32'h0FFF_F779;

  // R9
  a_r9_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq == |(flag_q & ie_q));

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == A_CTRL) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R3
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !reg_we) |=> ($stable(cyc_cnt) && $stable(ev0_cnt) && $stable(ev1_cnt)));

  // R3
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (rst)
    (en_q && !presc_q && !reg_we) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

  // R10 and R5
  a_r10_holes_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_CTRL) |=> ((reg_rdata & ~RD_MASK) == '0));
endmodule

bind perfmon_unit perfmon_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .en_q      (en_q),
  .presc_q   (presc_q),
  .ie_q      (ie_q),
  .flag_q    (flag_q),
  .cyc_cnt   (cyc_cnt),
  .ev0_cnt   (ev0_cnt),
  .ev1_cnt   (ev1_cnt)
);

// File: tb/perfmon_unit_tb.sv
`timescale 1ns/1ps
module perfmon_unit_tb;
  localparam int EVT_W = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [EVT_W-1:0] evt_pulse = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perfmon_unit #(.EVT_W(EVT_W)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic logic [31:0] wctrl(input logic en, input logic clr_ev,
      input logic clr_cyc, input logic presc, input logic [2:0] ie,
      input logic [2:0] w1c, input logic [7:0] s0, input logic [7:0] s1);
    return {4'b0, s1, s0, 1'b0, w1c, 1'b0, ie, presc, clr_cyc, clr_ev, en};
  endfunction

  function automatic logic [31:0] rctrl(input logic en, input logic presc,
      input logic [2:0] ie, input logic [2:0] fl, input logic [7:0] s0, input logic [7:0] s1);
    return {4'b0, s1, s0, 1'b0, fl, 1'b0, ie, presc, 2'b00, en};
  endfunction

  function automatic logic hit_of(input logic [EVT_W-1:0] p, input logic [7:0] sel);
    if (sel < 8'(EVT_W)) return p[sel[4:0]];
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e0, e1, c_before;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq}, 32'd0);
    rd(2'd0, v); chk("R1 control word", v, 32'h0FFF_F000);
    rd(2'd1, v); chk("R1 cycle counter", v, 32'd0);
    rd(2'd2, v); chk("R1 event counter 0", v, 32'd0);
    rd(2'd3, v); chk("R1 event counter 1", v, 32'd0);

    // R2 direct loads and address decode
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hCAFE_0001);
    wr(2'd3, 32'h0BAD_F00D);
    rd(2'd1, v); chk("R2 load cycle counter", v, 32'h1234_5678);
    rd(2'd2, v); chk("R2 load event counter 0", v, 32'hCAFE_0001);
    rd(2'd3, v); chk("R2 load event counter 1", v, 32'h0BAD_F00D);
    idle(5);
    rd(2'd1, v); chk("R3 disabled counter holds", v, 32'h1234_5678);

    // R10 holes and R5 readback of reset bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R10 R5 all-ones write readback", v, 32'h0FFF_F079);
    wr(2'd0, wctrl(0, 1, 1, 0, 3'b000, 3'b111, 8'hFF, 8'hFF));

    // R3 R6 random events, selectors 7 and 5
    wr(2'd0, wctrl(1, 1, 1, 0, 3'b000, 3'b000, 8'h07, 8'h05));
    e0 = 0; e1 = 0;
    for (int k = 0; k < 150; k++) begin
      evt_pulse = EVT_W'($urandom);
      @(negedge clk);
      e0 += 32'(hit_of(evt_pulse, 8'h07));
      e1 += 32'(hit_of(evt_pulse, 8'h05));
    end
    evt_pulse = '0;
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b000, 3'b000, 8'h07, 8'h05));
    rd(2'd2, v); chk("R6 random count sel 0x07", v, e0);
    rd(2'd3, v); chk("R6 random count sel 0x05", v, e1);
    rd(2'd1, v); chk("R3 cycle count over 151 edges", v, 32'd151);

    // R6 boundary codes 0x16 and 0x00 with preloaded counters
    wr(2'd2, 32'h0000_1000);
    wr(2'd3, 32'h0000_0005);
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b000, 3'b000, 8'h16, 8'h00));
    e0 = 32'h1000; e1 = 32'h5;
    for (int k = 0; k < 120; k++) begin
      evt_pulse = EVT_W'($urandom);
      @(negedge clk);
      e0 += 32'(hit_of(evt_pulse, 8'h16));
      e1 += 32'(hit_of(evt_pulse, 8'h00));
    end
    evt_pulse = '0;
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b000, 3'b000, 8'h16, 8'h00));
    rd(2'd2, v); chk("R6 random count sel 0x16", v, e0);
    rd(2'd3, v); chk("R6 random count sel 0x00", v, e1);

    // R6 undefined codes count nothing
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b000, 3'b000, 8'h30, 8'hFF));
    evt_pulse = '1;
    idle(20);
    evt_pulse = '0;
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b000, 3'b000, 8'h30, 8'hFF));
    rd(2'd2, v); chk("R6 code 0x30 counts nothing", v, e0);
    rd(2'd3, v); chk("R6 code 0xFF counts nothing", v, e1);

    // R5 reset bits act for one cycle on their own counters
    rd(2'd1, c_before);
    wr(2'd0, wctrl(0, 1, 0, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
    rd(2'd2, v); chk("R5 event reset clears counter 0", v, 32'd0);
    rd(2'd3, v); chk("R5 event reset clears counter 1", v, 32'd0);
    rd(2'd1, v); chk("R5 event reset leaves cycle counter", v, c_before);
    rd(2'd0, v); chk("R5 reset bits read zero", v, 32'h0FFF_F000);
    wr(2'd0, wctrl(0, 0, 1, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
    rd(2'd1, v); chk("R5 cycle reset clears cycle counter", v, 32'd0);

    // R4 prescale: 200, 64 and 63 counting edges
    wr(2'd0, wctrl(1, 0, 1, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
    idle(199);
    wr(2'd0, wctrl(0, 0, 0, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
    rd(2'd1, v); chk("R4 prescale 200 edges", v, 32'd3);
    wr(2'd0, wctrl(1, 0, 1, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
    idle(63);
    wr(2'd0, wctrl(0, 0, 0, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
    rd(2'd1, v); chk("R4 prescale 64 edges", v, 32'd1);
    wr(2'd0, wctrl(1, 0, 1, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
    idle(62);
    wr(2'd0, wctrl(0, 0, 0, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
    rd(2'd1, v); chk("R4 prescale 63 edges", v, 32'd0);

    // R7 R9 event counter 0 overflow with interrupt enabled
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'hFF));
    evt_pulse = '0; evt_pulse[7] = 1'b1;
    @(negedge clk);
    chk("R9 irq low before wrap", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R9 irq high at wrap edge", {31'b0, irq}, 32'd1);
    idle(2);
    evt_pulse = '0;
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'hFF));
    rd(2'd2, v); chk("R7 counter wrapped to 2", v, 32'd2);
    rd(2'd0, v); chk("R7 flag bit 8 set", v, rctrl(0, 0, 3'b001, 3'b001, 8'h07, 8'hFF));
    // second wrap keeps flag
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'hFF));
    evt_pulse[7] = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'hFF));
    rd(2'd0, v); chk("R7 flag stays after second wrap", v, rctrl(0, 0, 3'b001, 3'b001, 8'h07, 8'hFF));
    chk("R9 irq held while flag set", {31'b0, irq}, 32'd1);
    // R8 writing 1 clears, writing 0 leaves
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b001, 3'b000, 8'h07, 8'hFF));
    rd(2'd0, v); chk("R8 zero write keeps flag", v, rctrl(0, 0, 3'b001, 3'b001, 8'h07, 8'hFF));
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b001, 3'b001, 8'h07, 8'hFF));
    chk("R9 irq low after clear", {31'b0, irq}, 32'd0);
    rd(2'd0, v); chk("R8 one write clears flag", v, rctrl(0, 0, 3'b001, 3'b000, 8'h07, 8'hFF));

    // R8 wrap in the same cycle as the clearing write
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h05));
    evt_pulse[5] = 1'b1;
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b000, 3'b010, 8'hFF, 8'h05));
    evt_pulse = '0;
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h05));
    rd(2'd0, v); chk("R8 wrap beats clear", v, rctrl(0, 0, 3'b000, 3'b010, 8'hFF, 8'h05));
    chk("R9 irq low with enable off", {31'b0, irq}, 32'd0);

    // R7 R9 cycle counter overflow, interrupt disabled
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b000, 3'b010, 8'hFF, 8'hFF));
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, wctrl(1, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
    idle(1);
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
    rd(2'd1, v); chk("R7 cycle counter wrapped", v, 32'd1);
    rd(2'd0, v); chk("R7 cycle flag bit 10", v, rctrl(0, 0, 3'b000, 3'b100, 8'hFF, 8'hFF));
    chk("R9 irq masked by enable bit 6", {31'b0, irq}, 32'd0);
    wr(2'd0, wctrl(0, 0, 0, 0, 3'b100, 3'b000, 8'hFF, 8'hFF));
    chk("R9 irq rises when enable bit 6 set", {31'b0, irq}, 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule